// File: doc/BRIEF.md
# Serial Shift Register with Output Latch

This block is an 8-bit data register that is also the serial shift register. There is no buffer between the two. A CPU write loads the register directly, and a CPU read returns its current contents. On each shift clock the register moves left by one bit. The synchronised serial data input enters at bit 0. The most significant bit drives the serial data output through a latch.

A small control register holds a two-bit clock-source code, which picks where the shift clock comes from:
- **Software strobe.** A control write carrying a one in the strobe bit, together with code 00, produces exactly one shift in that cycle.
- **Timer.** An overflow pulse from an external timer shifts once per pulse.
- **External serial clock.** The clock passes through a synchroniser and is edge-detected. The register shifts on the rising edge or on the falling edge, depending on the code.

With an external clock, the output latch is transparent only during the half-period that comes before the sampling edge. Input sampling and output change therefore fall on opposite clock edges. With an internal source the latch is always transparent.

Top module: `sreg_serial`

## Requirements
- R1: After reset, `rd_data` reads 0x00, `sdo` is 0 and `ctrl_rd_data` reads 3'b000.
- R2: A data write (`wr_en`=1) loads `wr_data` at that clock edge, and `rd_data` shows it from the next cycle onward.
- R3: With code 00 (bits [2:1] of the control word) and no strobe, the register never shifts, even when timer pulses or serial clock edges arrive.
- R4: A control write of 3'b001 (code 00, strobe bit [0] = 1) shifts the register left exactly once. The new bit 0 is the synchronised data input as it stood before that edge.
- R5: With code 01, each `tmr_ovf` pulse shifts the register once. A control write of 3'b011 causes no shift, because the strobe has no effect under code 01.
- R6: With code 10, the register shifts on a rising edge of the synchronised `sck_in` and ignores falling edges.
- R7: With code 11, the register shifts on a falling edge of the synchronised `sck_in` and ignores rising edges.
- R8: A data write in the same cycle as a shift clock wins. The register takes `wr_data` and no shift is performed.
- R9: With code 10 or 11, `sdo` holds the pre-shift MSB from the sampling edge until the opposite edge, and a write during that time does not change `sdo`. After the opposite edge, `sdo` shows the current bit 7.
- R10: With code 00 or 01, the latch is transparent: `sdo` equals bit 7 of `rd_data` in every cycle, so a newly written MSB appears at once.
- R11: The strobe bit always reads back as 0 in `ctrl_rd_data[0]`, while bits [2:1] return the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Data register write value |
| rd_data | output | 8 | Current shift register contents |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 3 | Control word: [2:1] clock-source code, [0] strobe |
| ctrl_rd_data | output | 3 | Stored code in [2:1], strobe reads 0 in [0] |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| sck_in | input | 1 | Asynchronous serial clock input |
| sdi_in | input | 1 | Asynchronous serial data input |
| sdo | output | 1 | Latched serial data output |

## Verification
The software-strobe shift is driven from a vector table of data words and input bits. The table includes all-ones, all-zeros, a lone MSB and a lone LSB, so a wrong shift direction, a lost bit 0 or a wrong sampled input each give a distinct result.

Each clock source is then given every other kind of shift stimulus. Timer pulses and serial edges are applied under the strobe code, the strobe is applied under the timer code, and each polarity receives both edges. This tells source selection apart from polarity selection.

Write-versus-shift collisions, and writes made while the latch is closed, separate the priority rule from the latch hold behaviour.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_TIMER    = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_src_e;

  localparam int CTRL_W = 3;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Stage 0 samples the pin; each later stage takes the one before it.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb chain_d[g] = async_i;
      end else begin : g_next
        always_comb chain_d[g] = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/sreg_clksel.sv
module sreg_clksel
  import sreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src_q,
  input  logic     strobe_i,
  input  logic     tmr_ovf_i,
  input  logic     sck_lvl_i,
  output logic     shift_o,
  output logic     latch_open_o
);

  logic sck_prev_q;
  logic sck_prev_d;
  logic rise;
  logic fall;
  logic src_shift;

  // Previous synchronised clock level, used for edge detection.
  always_comb sck_prev_d = sck_lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_prev_d;
  end

  assign rise = sck_lvl_i & ~sck_prev_q;
  assign fall = ~sck_lvl_i & sck_prev_q;

  always_comb begin
    src_shift    = 1'b0;
    latch_open_o = 1'b1;
    unique case (src_q)
      CS_SOFT:  begin
        src_shift    = 1'b0;
        latch_open_o = 1'b1;
      end
      CS_TIMER: begin
        src_shift    = tmr_ovf_i;
        latch_open_o = 1'b1;
      end
      CS_EXT_RISE: begin
        src_shift    = rise;
        latch_open_o = ~sck_lvl_i;  // open in the half before the rising edge
      end
      CS_EXT_FALL: begin
        src_shift    = fall;
        latch_open_o = sck_lvl_i;   // open in the half before the falling edge
      end
      default: begin
        src_shift    = 1'b0;
        latch_open_o = 1'b1;
      end
    endcase
  end

  assign shift_o = strobe_i | src_shift;

endmodule

// File: rtl/sreg_outlatch.sv
module sreg_outlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic msb_i,
  output logic sdo_o
);

  logic hold_q;
  logic hold_d;

  always_comb hold_d = open_i ? msb_i : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign sdo_o = open_i ? msb_i : hold_q;

endmodule

// File: rtl/sreg_serial.sv
module sreg_serial
  import sreg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ctrl_wr_en,
  input  logic [2:0]        ctrl_wr_data,
  output logic [2:0]        ctrl_rd_data,
  input  logic              tmr_ovf,
  input  logic              sck_in,
  input  logic              sdi_in,
  output logic              sdo
);

  localparam int MSB = DATA_W - 1;

  clk_src_e          src_q, src_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              sck_lvl, sdi_lvl;
  logic              strobe, shift, latch_open;

  sreg_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .async_i(sck_in), .level_o(sck_lvl)
  );

  sreg_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .async_i(sdi_in), .level_o(sdi_lvl)
  );

  // The strobe acts only when the control word written with it selects software clocking.
  assign strobe = ctrl_wr_en & ctrl_wr_data[0] &
                  (clk_src_e'(ctrl_wr_data[2:1]) == CS_SOFT);

  sreg_clksel u_clksel (
    .clk(clk), .rst_n(rst_n), .src_q(src_q), .strobe_i(strobe),
    .tmr_ovf_i(tmr_ovf), .sck_lvl_i(sck_lvl),
    .shift_o(shift), .latch_open_o(latch_open)
  );

  always_comb src_d = ctrl_wr_en ? clk_src_e'(ctrl_wr_data[2:1]) : src_q;

  // A CPU write takes priority over a shift in the same cycle.
  always_comb begin
    if (wr_en)      data_d = wr_data;
    else if (shift) data_d = {data_q[MSB-1:0], sdi_lvl};
    else            data_d = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= CS_SOFT;
      data_q <= '0;
    end else begin
      src_q  <= src_d;
      data_q <= data_d;
    end
  end

  sreg_outlatch u_outlatch (
    .clk(clk), .rst_n(rst_n), .open_i(latch_open), .msb_i(data_q[MSB]), .sdo_o(sdo)
  );

  assign rd_data      = data_q;
  assign ctrl_rd_data = {src_q, 1'b0};

endmodule

// File: rtl/sreg_serial_chk.sv
module sreg_serial_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              ctrl_wr_en,
  input logic [2:0]        ctrl_wr_data,
  input logic [2:0]        ctrl_rd_data,
  input logic              tmr_ovf,
  input logic              sdo
);

  // Data write wins over any shift.
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // Code 00 without a strobe leaves the register unchanged.
  p_soft_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd_data[2:1] == 2'b00 && !wr_en &&
     !(ctrl_wr_en && ctrl_wr_data == 3'b001)) |=> $stable(rd_data));

  // A strobe write shifts left by one.
  p_strobe_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_en && ctrl_wr_data == 3'b001 && !wr_en) |=>
      rd_data[DATA_W-1:1] == $past(rd_data[DATA_W-2:0]));

  // A timer pulse under code 01 shifts left by one.
  p_timer_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd_data[2:1] == 2'b01 && tmr_ovf && !wr_en &&
     !(ctrl_wr_en && ctrl_wr_data == 3'b001)) |=>
      rd_data[DATA_W-1:1] == $past(rd_data[DATA_W-2:0]));

  // With an internal source the output follows the MSB.
  p_internal_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd_data[2] == 1'b0) |-> sdo == rd_data[DATA_W-1]);

endmodule

bind sreg_serial sreg_serial_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
  .tmr_ovf(tmr_ovf), .sdo(sdo)
);

// File: tb/sreg_serial_bench.sv
`timescale 1ns/1ps
module sreg_serial_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ctrl_wr_en = 1'b0;
  logic [2:0] ctrl_wr_data = '0;
  logic [2:0] ctrl_rd_data;
  logic       tmr_ovf = 1'b0;
  logic       sck_in = 1'b0;
  logic       sdi_in = 1'b0;
  logic       sdo;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sreg_serial u_sreg_serial (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
    .tmr_ovf(tmr_ovf), .sck_in(sck_in), .sdi_in(sdi_in), .sdo(sdo)
  );

  // Strobe shift vectors: write value, serial input bit, expected result.
  localparam logic [7:0] V_WD  [0:5] = '{8'hA5, 8'h01, 8'hFF, 8'h80, 8'h3C, 8'h00};
  localparam logic       V_SDI [0:5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [7:0] V_EXP [0:5] = '{8'h4B, 8'h02, 8'hFF, 8'h00, 8'h78, 8'h01};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cwr(input logic [2:0] c);
    @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_data = c;
    @(negedge clk); ctrl_wr_en = 1'b0;
  endtask

  task automatic pulse_tmr;
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic set_sck(input logic v);
    @(negedge clk); sck_in = v;
    idle(4);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 sdo", {7'd0, sdo}, 8'h00);
    chk("R1 ctrl", {5'd0, ctrl_rd_data}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2 / R4 / R10: table of strobe shifts under code 00
    for (int i = 0; i < 6; i++) begin
      sdi_in = V_SDI[i];
      wr(V_WD[i]);
      chk("R2 write", rd_data, V_WD[i]);
      chk("R10 sdo follows write", {7'd0, sdo}, {7'd0, V_WD[i][7]});
      idle(3);
      cwr(3'b001);
      chk("R4 strobe shift", rd_data, V_EXP[i]);
      chk("R10 sdo after shift", {7'd0, sdo}, {7'd0, V_EXP[i][7]});
      chk("R11 strobe reads 0", {5'd0, ctrl_rd_data}, 8'h00);
    end

    // R3: code 00, timer and serial edges cause no shift
    wr(8'h96);
    pulse_tmr();
    set_sck(1'b1);
    set_sck(1'b0);
    chk("R3 no shift", rd_data, 8'h96);

    // R5: timer shifts, strobe ignored under code 01
    cwr(3'b010);
    sdi_in = 1'b1; idle(3);
    wr(8'h81);
    pulse_tmr();
    chk("R5 timer shift", rd_data, 8'h03);
    cwr(3'b011);
    chk("R5 strobe ignored", rd_data, 8'h03);
    chk("R11 code kept strobe 0", {5'd0, ctrl_rd_data}, 8'h02);

    // R8: write collides with timer pulse
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A; tmr_ovf = 1'b1;
    @(negedge clk); wr_en = 1'b0; tmr_ovf = 1'b0;
    chk("R8 write wins", rd_data, 8'h5A);

    // R6: rising-edge source
    cwr(3'b100);
    wr(8'h01);
    set_sck(1'b1);
    chk("R6 rising shift", rd_data, 8'h03);
    set_sck(1'b0);
    chk("R6 falling ignored", rd_data, 8'h03);

    // R7: falling-edge source
    cwr(3'b110);
    sdi_in = 1'b0; idle(3);
    set_sck(1'b1);
    chk("R7 rising ignored", rd_data, 8'h03);
    set_sck(1'b0);
    chk("R7 falling shift", rd_data, 8'h06);

    // R9: latch behaviour with rising-edge source
    cwr(3'b101);
    chk("R11 ext code strobe 0", {5'd0, ctrl_rd_data}, 8'h04);
    chk("R9 no strobe shift ext", rd_data, 8'h06);
    wr(8'h80);
    chk("R9 open while low", {7'd0, sdo}, 8'h01);
    set_sck(1'b1);
    chk("R9 shifted", rd_data, 8'h00);
    chk("R9 hold old MSB", {7'd0, sdo}, 8'h01);
    wr(8'h7F);
    chk("R9 write while closed", {7'd0, sdo}, 8'h01);
    set_sck(1'b0);
    chk("R9 reopen rd", rd_data, 8'h7F);
    chk("R9 reopen sdo", {7'd0, sdo}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule